// File: doc/BRIEF.md
# Branch and Next-PC Unit

This unit decides where a small core fetches next. Each cycle it receives the current program counter of a 16-bit, word-addressed instruction memory, a branch kind, the first source register, the already-selected second operand (an 8-bit immediate or a register), a signed word offset, a 16-bit jump immediate with its select bit, and a sequential-advance request. It returns the next program counter. For jump-and-link it also raises a link write enable and gives the return address as the link value.

The unit is purely combinational. A condition evaluator produces a single "take" decision. A route decoder maps the kind and that decision onto one of four path states. A target generator forms the three candidate addresses. The path states and what selects them are:
- PATH_HOLD: no branch kind and no advance request. The PC is kept.
- PATH_SEQ: no branch kind with an advance request, or a conditional branch whose condition fails. The result is PC+1.
- PATH_REL: a conditional branch whose condition holds, or branch-always. The result is PC plus the offset.
- PATH_ABS: jump or jump-and-link. The result is the absolute target.

Comparisons place operand 2 on the left, so "greater-than" asks whether operand 2 exceeds RS1.

Top module: `next_pc_unit`

## Requirements
- R1: Kind codes 1 to 6 are, in that order, greater-than, greater-or-equal, less-than, less-or-equal, equal and not-equal. Each compares `opnd2` (left side) with `rs1` (right side) as unsigned numbers. When the condition holds, `nxt_pc` = `cur_pc` + offset. Otherwise it is `cur_pc`+1.
- R2: `br_off` is a 10-bit two's-complement word offset. It is sign-extended to 16 bits before the add, and the sum wraps modulo 2^16.
- R3: Kind 7 (branch-always) gives `cur_pc` + offset regardless of the operands.
- R4: Kind 8 branches when `rs1` bit `opnd2[4:0]` is 1, and kind 9 branches when that bit is 0. Bits of `opnd2` above bit 4 have no effect.
- R5: Kind 10 (jump) gives `jmp_imm` when `jmp_use_imm` is 1, and `opnd2[15:0]` otherwise.
- R6: Kind 11 (jump-and-link) gives the same target as kind 10, raises `link_we`, and drives `link_val` = `cur_pc`+1.
- R7: `link_we` is 0 for every kind other than 11.
- R8: Kind 0 gives `cur_pc`+1 when `seq_adv` is 1, and `cur_pc` when it is 0. Codes 12 to 15 behave as kind 0. `seq_adv` has no effect on any other kind.
- R9: Every PC+1 result wraps from 0xFFFF to 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cur_pc | input | 16 | Current program counter (word address) |
| br_kind | input | 4 | Branch kind code (see R1 to R8) |
| rs1 | input | 32 | First source register value |
| opnd2 | input | 32 | Second operand: zero-extended immediate or register value |
| br_off | input | 10 | Signed word offset for relative branches |
| jmp_imm | input | 16 | Absolute jump immediate |
| jmp_use_imm | input | 1 | Selects `jmp_imm` (1) or `opnd2[15:0]` (0) as the jump target |
| seq_adv | input | 1 | Sequential advance request for non-branch kinds |
| nxt_pc | output | 16 | Next program counter |
| link_we | output | 1 | Link register write enable |
| link_val | output | 16 | Return address, `cur_pc`+1 |

## Verification
Each compare is driven with operand pairs on both sides of the condition and with equal operands. This separates strict conditions from non-strict ones and catches an operand order that was swapped. One pair places a value with the top bit set in RS1, so a signed compare would give the opposite result from the required unsigned one. Offsets at +511 and -512, and PCs near 0xFFFF, expose a missing sign extension or missing wraparound. A sweep across all 32 bit positions uses operand-2 values with high junk bits set, which shows that the bit index is masked correctly.

// File: rtl/bnpc_pkg.sv
package bnpc_pkg;

    typedef enum logic [3:0] {
        KIND_NONE   = 4'd0,
        KIND_GT     = 4'd1,
        KIND_GE     = 4'd2,
        KIND_LT     = 4'd3,
        KIND_LE     = 4'd4,
        KIND_EQ     = 4'd5,
        KIND_NE     = 4'd6,
        KIND_ALWAYS = 4'd7,
        KIND_BITSET = 4'd8,
        KIND_BITCLR = 4'd9,
        KIND_JUMP   = 4'd10,
        KIND_JAL    = 4'd11
    } br_kind_e;

    typedef enum logic [1:0] {
        PATH_HOLD = 2'd0,
        PATH_SEQ  = 2'd1,
        PATH_REL  = 2'd2,
        PATH_ABS  = 2'd3
    } path_e;

endpackage

// File: rtl/bnpc_cond.sv
module bnpc_cond
    import bnpc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [3:0]        kind,
    input  logic [DATA_W-1:0] rs1,
    input  logic [DATA_W-1:0] opnd2,
    output logic              take
);
    localparam int BIT_W = $clog2(DATA_W);

    logic [BIT_W-1:0] bit_idx;
    logic             sel_bit;

    always_comb begin
        bit_idx = opnd2[BIT_W-1:0];
        sel_bit = rs1[bit_idx];
    end

    always_comb begin
        unique case (kind)
            KIND_GT:     take = (opnd2 >  rs1);
            KIND_GE:     take = (opnd2 >= rs1);
            KIND_LT:     take = (opnd2 <  rs1);
            KIND_LE:     take = (opnd2 <= rs1);
            KIND_EQ:     take = (opnd2 == rs1);
            KIND_NE:     take = (opnd2 != rs1);
            KIND_ALWAYS: take = 1'b1;
            KIND_BITSET: take = sel_bit;
            KIND_BITCLR: take = ~sel_bit;
            default:     take = 1'b0;
        endcase
    end

    always_comb begin
        // R1
        eq_take_chk: assert (!(kind == KIND_EQ && take) || (opnd2 == rs1))
            else $error("equal branch taken on unequal operands");
        // R1
        gt_take_chk: assert (!(kind == KIND_GT && take) || (opnd2 != rs1))
            else $error("greater-than taken on equal operands");
    end

endmodule

// File: rtl/bnpc_route.sv
module bnpc_route
    import bnpc_pkg::*;
(
    input  logic [3:0] kind,
    input  logic       take,
    input  logic       seq_adv,
    output path_e      path,
    output logic       link_we
);
    always_comb begin
        link_we = 1'b0;
        unique case (kind)
            KIND_GT, KIND_GE, KIND_LT, KIND_LE, KIND_EQ, KIND_NE,
            KIND_BITSET, KIND_BITCLR:
                path = take ? PATH_REL : PATH_SEQ;
            KIND_ALWAYS:
                path = PATH_REL;
            KIND_JUMP:
                path = PATH_ABS;
            KIND_JAL: begin
                path    = PATH_ABS;
                link_we = 1'b1;
            end
            default:
                path = seq_adv ? PATH_SEQ : PATH_HOLD;
        endcase
    end

    always_comb begin
        // R7
        link_only_jal_chk: assert (!link_we || kind == KIND_JAL)
            else $error("link write outside jump-and-link");
        // R3
        always_rel_chk: assert (kind != KIND_ALWAYS || path == PATH_REL)
            else $error("branch-always not relative");
    end

endmodule

// File: rtl/bnpc_target.sv
module bnpc_target #(
    parameter int PC_W  = 16,
    parameter int OFF_W = 10
) (
    input  logic [PC_W-1:0]  cur_pc,
    input  logic [OFF_W-1:0] off,
    input  logic [PC_W-1:0]  jmp_imm,
    input  logic             jmp_use_imm,
    input  logic [PC_W-1:0]  reg_tgt,
    output logic [PC_W-1:0]  seq_pc,
    output logic [PC_W-1:0]  rel_pc,
    output logic [PC_W-1:0]  abs_pc
);
    localparam int EXT_W = PC_W - OFF_W;

    logic [PC_W-1:0] off_ext;

    always_comb begin
        off_ext = {{EXT_W{off[OFF_W-1]}}, off};
        seq_pc  = cur_pc + {{(PC_W-1){1'b0}}, 1'b1};
        rel_pc  = cur_pc + off_ext;
        abs_pc  = jmp_use_imm ? jmp_imm : reg_tgt;
    end

    always_comb begin
        // R2
        rel_sign_chk: assert (off[OFF_W-1] || (rel_pc - cur_pc) < (PC_W'(1) << (OFF_W-1)))
            else $error("positive offset moved PC out of range");
    end

endmodule

// File: rtl/next_pc_unit.sv
module next_pc_unit
    import bnpc_pkg::*;
#(
    parameter int PC_W   = 16,
    parameter int DATA_W = 32,
    parameter int OFF_W  = 10
) (
    input  logic [PC_W-1:0]   cur_pc,
    input  logic [3:0]        br_kind,
    input  logic [DATA_W-1:0] rs1,
    input  logic [DATA_W-1:0] opnd2,
    input  logic [OFF_W-1:0]  br_off,
    input  logic [PC_W-1:0]   jmp_imm,
    input  logic              jmp_use_imm,
    input  logic              seq_adv,
    output logic [PC_W-1:0]   nxt_pc,
    output logic              link_we,
    output logic [PC_W-1:0]   link_val
);
    logic            take;
    path_e           path;
    logic [PC_W-1:0] seq_pc;
    logic [PC_W-1:0] rel_pc;
    logic [PC_W-1:0] abs_pc;

    bnpc_cond #(.DATA_W(DATA_W)) u_cond (
        .kind  (br_kind),
        .rs1   (rs1),
        .opnd2 (opnd2),
        .take  (take)
    );

    bnpc_route u_route (
        .kind    (br_kind),
        .take    (take),
        .seq_adv (seq_adv),
        .path    (path),
        .link_we (link_we)
    );

    bnpc_target #(.PC_W(PC_W), .OFF_W(OFF_W)) u_target (
        .cur_pc      (cur_pc),
        .off         (br_off),
        .jmp_imm     (jmp_imm),
        .jmp_use_imm (jmp_use_imm),
        .reg_tgt     (opnd2[PC_W-1:0]),
        .seq_pc      (seq_pc),
        .rel_pc      (rel_pc),
        .abs_pc      (abs_pc)
    );

    always_comb begin
        unique case (path)
            PATH_HOLD: nxt_pc = cur_pc;
            PATH_SEQ:  nxt_pc = seq_pc;
            PATH_REL:  nxt_pc = rel_pc;
            PATH_ABS:  nxt_pc = abs_pc;
            default:   nxt_pc = cur_pc;
        endcase
        link_val = seq_pc;
    end

    always_comb begin
        // R6
        link_ret_chk: assert (!link_we || (link_val - cur_pc) == PC_W'(1))
            else $error("link value is not PC+1");
        // R5
        jump_imm_chk: assert (!(br_kind == KIND_JUMP && jmp_use_imm) || nxt_pc == jmp_imm)
            else $error("jump ignored its immediate");
        // R8
        hold_chk: assert (!(br_kind == 4'd0 && !seq_adv) || nxt_pc == cur_pc)
            else $error("idle kind did not hold PC");
    end

endmodule

// File: tb/test_next_pc_unit.sv
module test_next_pc_unit;

    typedef struct packed {
        logic [3:0]  kind;
        logic [15:0] pc;
        logic [31:0] rs1;
        logic [31:0] op2;
        logic [9:0]  off;
        logic [15:0] jimm;
        logic        jsel;
        logic        adv;
        logic [15:0] exp_pc;
        logic        exp_we;
        logic [15:0] exp_link;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        // R1 gt taken, R1 gt not taken (order), R1 gt equal
        '{4'd1, 16'h0100, 32'd5, 32'd9, 10'd4, 16'h0, 1'b0, 1'b1, 16'h0104, 1'b0, 16'h0},
        '{4'd1, 16'h0100, 32'd9, 32'd5, 10'd4, 16'h0, 1'b0, 1'b1, 16'h0101, 1'b0, 16'h0},
        '{4'd1, 16'h0400, 32'd7, 32'd7, 10'd4, 16'h0, 1'b0, 1'b0, 16'h0401, 1'b0, 16'h0},
        // R1 ge equal taken, negative offset R2
        '{4'd2, 16'h0200, 32'd7, 32'd7, 10'h3FD, 16'h0, 1'b0, 1'b0, 16'h01FD, 1'b0, 16'h0},
        // R1 lt unsigned
        '{4'd3, 16'h0300, 32'h80000000, 32'd3, 10'h010, 16'h0, 1'b0, 1'b1, 16'h0310, 1'b0, 16'h0},
        // R1 le not taken
        '{4'd4, 16'h0300, 32'd4, 32'd10, 10'h010, 16'h0, 1'b0, 1'b1, 16'h0301, 1'b0, 16'h0},
        // R1 eq taken, R2 +511
        '{4'd5, 16'h0010, 32'hDEADBEEF, 32'hDEADBEEF, 10'h1FF, 16'h0, 1'b0, 1'b1, 16'h020F, 1'b0, 16'h0},
        // R1 ne not taken
        '{4'd6, 16'h0010, 32'hDEADBEEF, 32'hDEADBEEF, 10'h1FF, 16'h0, 1'b0, 1'b1, 16'h0011, 1'b0, 16'h0},
        // R1 ne taken, R2 -512 wrap
        '{4'd6, 16'h0100, 32'd2, 32'd1, 10'h200, 16'h0, 1'b0, 1'b1, 16'hFF00, 1'b0, 16'h0},
        // R3 always, R2 wrap upward
        '{4'd7, 16'hFFFE, 32'd0, 32'd0, 10'd5, 16'h0, 1'b0, 1'b0, 16'h0003, 1'b0, 16'h0},
        // R4 bit set with high junk in opnd2
        '{4'd8, 16'h0040, 32'h00000400, 32'h0000002A, 10'd8, 16'h0, 1'b0, 1'b1, 16'h0048, 1'b0, 16'h0},
        // R4 bit clear not taken
        '{4'd9, 16'h0040, 32'h00000400, 32'h0000002A, 10'd8, 16'h0, 1'b0, 1'b1, 16'h0041, 1'b0, 16'h0},
        // R4 bit clear taken on bit 31
        '{4'd9, 16'h0050, 32'h0, 32'd31, 10'd2, 16'h0, 1'b0, 1'b1, 16'h0052, 1'b0, 16'h0},
        // R5 jump immediate, R5 jump register
        '{4'd10, 16'h0100, 32'd0, 32'h12345678, 10'd3, 16'hABCD, 1'b1, 1'b0, 16'hABCD, 1'b0, 16'h0},
        '{4'd10, 16'h0100, 32'd0, 32'h12345678, 10'd3, 16'hABCD, 1'b0, 1'b0, 16'h5678, 1'b0, 16'h0},
        // R6 jal immediate, R6/R9 jal register with link wrap
        '{4'd11, 16'h0777, 32'd0, 32'd0, 10'd0, 16'h0123, 1'b1, 1'b1, 16'h0123, 1'b1, 16'h0778},
        '{4'd11, 16'hFFFF, 32'd0, 32'h00004444, 10'd0, 16'h0123, 1'b0, 1'b0, 16'h4444, 1'b1, 16'h0000},
        // R8 sequential, R8 hold
        '{4'd0, 16'h1234, 32'd1, 32'd1, 10'd9, 16'h0, 1'b0, 1'b1, 16'h1235, 1'b0, 16'h0},
        '{4'd0, 16'h1234, 32'd1, 32'd1, 10'd9, 16'h0, 1'b0, 1'b0, 16'h1234, 1'b0, 16'h0},
        // R8 reserved code, R9 wrap
        '{4'd14, 16'hFFFF, 32'd0, 32'd0, 10'd9, 16'h0, 1'b1, 1'b1, 16'h0000, 1'b0, 16'h0},
        // R7 reserved code with hold, no link
        '{4'd12, 16'h0800, 32'd0, 32'd0, 10'd9, 16'h0, 1'b1, 1'b0, 16'h0800, 1'b0, 16'h0}
    };

    logic        clk = 1'b0;
    logic [15:0] cur_pc = '0;
    logic [3:0]  br_kind = '0;
    logic [31:0] rs1 = '0;
    logic [31:0] opnd2 = '0;
    logic [9:0]  br_off = '0;
    logic [15:0] jmp_imm = '0;
    logic        jmp_use_imm = 1'b0;
    logic        seq_adv = 1'b0;
    logic [15:0] nxt_pc;
    logic        link_we;
    logic [15:0] link_val;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    next_pc_unit i_next_pc_unit (
        .cur_pc      (cur_pc),
        .br_kind     (br_kind),
        .rs1         (rs1),
        .opnd2       (opnd2),
        .br_off      (br_off),
        .jmp_imm     (jmp_imm),
        .jmp_use_imm (jmp_use_imm),
        .seq_adv     (seq_adv),
        .nxt_pc      (nxt_pc),
        .link_we     (link_we),
        .link_val    (link_val)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=<5000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // idle state after power-up: all inputs zero holds PC at 0 (R8, R7)
        @(posedge clk);
        #3;
        check("R8 idle nxt_pc", nxt_pc, 16'h0000);
        check("R7 idle link_we", {15'd0, link_we}, 16'h0000);

        for (int i = 0; i < NV; i++) begin
            @(posedge clk);
            cur_pc      = VECS[i].pc;
            br_kind     = VECS[i].kind;
            rs1         = VECS[i].rs1;
            opnd2       = VECS[i].op2;
            br_off      = VECS[i].off;
            jmp_imm     = VECS[i].jimm;
            jmp_use_imm = VECS[i].jsel;
            seq_adv     = VECS[i].adv;
            #3;
            check($sformatf("R1-table vec %0d nxt_pc", i), nxt_pc, VECS[i].exp_pc);
            check($sformatf("R7 vec %0d link_we", i), {15'd0, link_we}, {15'd0, VECS[i].exp_we});
            if (VECS[i].exp_we)
                check($sformatf("R6 vec %0d link_val", i), link_val, VECS[i].exp_link);
        end

        // R4: every bit position, junk in opnd2[7:5]
        for (int b = 0; b < 32; b++) begin
            @(posedge clk);
            cur_pc  = 16'h2000;
            br_off  = 10'd16;
            rs1     = 32'h1 << b;
            opnd2   = 32'(b) | 32'hE0;
            br_kind = 4'd8;
            #3;
            check("R4 bitset sweep", nxt_pc, 16'h2010);
            br_kind = 4'd9;
            #3;
            check("R4 bitclr sweep", nxt_pc, 16'h2001);
        end

        // R8: seq_adv ignored by a branch kind
        @(posedge clk);
        cur_pc  = 16'h3000;
        br_kind = 4'd7;
        br_off  = 10'h3FF;
        seq_adv = 1'b0;
        #3;
        check("R8 adv ignored adv0", nxt_pc, 16'h2FFF);
        seq_adv = 1'b1;
        #3;
        check("R8 adv ignored adv1", nxt_pc, 16'h2FFF);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule